// File: doc/BRIEF.md
# Banked Integer Dot-Product Unit

This block forms the dot product of two unsigned integer vectors of `VEC_LEN` elements. Each operand is stored in an on-chip memory split cyclically over `LANES` banks, so element `e` sits in bank `e % LANES` at row `e / LANES`. The block has one multiply lane per bank, and each lane is wired to its own bank only. Because of this, no bank multiplexer is needed. The number of lanes equals the number of banks and divides the vector length.

A start pulse clears the accumulator and begins a run of `VEC_LEN/LANES` groups. Groups are processed one after another with no overlap. In each group the block:
- issues one row address to every bank of both operands,
- captures the lane products one cycle after the banks return data,
- folds the products through an adder tree into the accumulator.

When the last group has been folded in, `done` pulses for one cycle and `result` holds the sum.

Top module: `banked_dot_unit`

## Requirements
- R1: While reset is held and right after it, `done` is 0, `result` is 0 and every address output is 0.
- R2: A `start` sampled high while the unit is idle clears the accumulator, so `result` reads 0 in the cycles that follow, until the first group is folded in.
- R3: During group `g` (counting from 0), every address slice of both `a_addr` and `b_addr` carries row `g`. Lane `j` uses slice `j` (bits `j*ADDR_W` upward) and so handles element `LANES*g + j`. Groups run in ascending order.
- R4: The bank memories have a one-cycle read latency. Read data returned in the cycle after an address is issued is the data used for that group.
- R5: `result` equals the sum over all elements of `a[e]*b[e]`. The operands are unsigned, each product is zero-extended, and the sum is taken modulo 2^ACC_W.
- R6: A run takes three cycles per group. `done` is high in the cycle that begins `3*VEC_LEN/LANES` rising edges after the edge that accepted `start`, and it stays high for exactly one cycle.
- R7: `result` keeps the final sum from the `done` cycle until the next accepted `start`.
- R8: A `start` that arrives while a run is in progress is ignored. It changes neither the final sum nor the cycle in which `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run when idle |
| a_addr | output | LANES*ADDR_W | Row address per bank of operand A; slice j goes to bank j |
| a_rdata | input | LANES*DATA_W | Read data per bank of operand A, one cycle after its address |
| b_addr | output | LANES*ADDR_W | Row address per bank of operand B |
| b_rdata | input | LANES*DATA_W | Read data per bank of operand B |
| done | output | 1 | One-cycle pulse when the sum is final |
| result | output | ACC_W | Accumulated dot product |

## Verification
The assertions assume that `start` is a clean synchronous level and that the bank memories behave as synchronous reads. They also assume that `rst_n` is released only between clock edges. The bench models both banked memories as registered lookups that are indexed by the design's own address slices. It changes `start` only on falling edges. It waits for `done` before starting another run, except in the one run that deliberately pulses `start` mid-run.

// File: rtl/dotp_pkg.sv
package dotp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_FETCH,
    ST_COMBINE,
    ST_FINISH
  } dot_state_t;

  // Address width for a given number of rows, never below one bit.
  function automatic int row_bits(input int rows);
    return (rows > 1) ? $clog2(rows) : 1;
  endfunction

endpackage

// File: rtl/dot_ctrl.sv
module dot_ctrl
  import dotp_pkg::*;
#(
  parameter int GROUPS = 4,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] row,
  output logic              capture,
  output logic              combine_fire,
  output logic              start_take,
  output logic              busy,
  output logic              done
);

  localparam logic [ADDR_W-1:0] LAST_ROW = ADDR_W'(GROUPS - 1);

  dot_state_t state;

  assign start_take   = (state == ST_IDLE) && start;
  assign capture      = (state == ST_FETCH);
  assign combine_fire = (state == ST_COMBINE);
  assign busy         = (state == ST_ISSUE) || (state == ST_FETCH) || (state == ST_COMBINE);
  assign done         = (state == ST_FINISH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      row   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_ISSUE;
            row   <= '0;
          end
        end
        ST_ISSUE:   state <= ST_FETCH;
        ST_FETCH:   state <= ST_COMBINE;
        ST_COMBINE: begin
          if (row == LAST_ROW) begin
            state <= ST_FINISH;
            row   <= '0;
          end else begin
            state <= ST_ISSUE;
            row   <= row + 1'b1;
          end
        end
        ST_FINISH:  state <= ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/lane_mult.sv
module lane_mult #(
  parameter int DATA_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  capture,
  input  logic [DATA_W-1:0]     opa,
  input  logic [DATA_W-1:0]     opb,
  output logic [2*DATA_W-1:0]   prod
);

  function automatic logic [2*DATA_W-1:0] umul(input logic [DATA_W-1:0] x,
                                               input logic [DATA_W-1:0] y);
    return (2*DATA_W)'(x) * (2*DATA_W)'(y);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prod <= '0;
    else if (capture) prod <= umul(opa, opb);
  end

endmodule

// File: rtl/reduce_tree.sv
module reduce_tree #(
  parameter int N     = 4,
  parameter int IN_W  = 16,
  parameter int OUT_W = 32
) (
  input  logic [N*IN_W-1:0] leaves,
  output logic [OUT_W-1:0]  total
);

  // Heap layout: node i has children 2i+1 and 2i+2; leaves occupy N-1..2N-2.
  logic [OUT_W-1:0] node [2*N-1];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[N-1+j] = OUT_W'(leaves[j*IN_W +: IN_W]);
  end

  for (genvar i = 0; i < N-1; i++) begin : g_add
    assign node[i] = node[2*i+1] + node[2*i+2];
  end

  assign total = node[0];

endmodule

// File: rtl/banked_dot_unit.sv
module banked_dot_unit
  import dotp_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int VEC_LEN = 16,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 32,
  localparam int GROUPS = VEC_LEN / LANES,
  localparam int ADDR_W = row_bits(GROUPS),
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  output logic [LANES*ADDR_W-1:0] a_addr,
  input  logic [LANES*DATA_W-1:0] a_rdata,
  output logic [LANES*ADDR_W-1:0] b_addr,
  input  logic [LANES*DATA_W-1:0] b_rdata,
  output logic                    done,
  output logic [ACC_W-1:0]        result
);

  logic [ADDR_W-1:0]       row;
  logic                    capture;
  logic                    combine_fire;
  logic                    start_take;
  logic                    busy;
  logic [LANES*PROD_W-1:0] prods;
  logic [ACC_W-1:0]        group_sum;
  logic [ACC_W-1:0]        acc;

  dot_ctrl #(.GROUPS(GROUPS), .ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .row          (row),
    .capture      (capture),
    .combine_fire (combine_fire),
    .start_take   (start_take),
    .busy         (busy),
    .done         (done)
  );

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign a_addr[j*ADDR_W +: ADDR_W] = row;
    assign b_addr[j*ADDR_W +: ADDR_W] = row;

    lane_mult #(.DATA_W(DATA_W)) u_mult (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .opa     (a_rdata[j*DATA_W +: DATA_W]),
      .opb     (b_rdata[j*DATA_W +: DATA_W]),
      .prod    (prods[j*PROD_W +: PROD_W])
    );
  end

  reduce_tree #(.N(LANES), .IN_W(PROD_W), .OUT_W(ACC_W)) u_tree (
    .leaves (prods),
    .total  (group_sum)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc <= '0;
    else if (start_take)   acc <= '0;
    else if (combine_fire) acc <= acc + group_sum;
  end

  assign result = acc;

endmodule

// File: rtl/dot_unit_chk.sv
module dot_unit_chk #(
  parameter int LANES  = 4,
  parameter int GROUPS = 4,
  parameter int ADDR_W = 2,
  parameter int ACC_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    start,
  input logic                    done,
  input logic [ACC_W-1:0]        result,
  input logic [LANES*ADDR_W-1:0] a_addr,
  input logic [LANES*ADDR_W-1:0] b_addr,
  input logic                    busy,
  input logic                    combine_fire,
  input logic                    start_take
);

  localparam int CW = $clog2(GROUPS + 1) + 1;

  logic [CW-1:0] folds;
  logic          lanes_same;

  always_comb begin
    lanes_same = (a_addr == b_addr);
    for (int j = 1; j < LANES; j++) begin
      if (a_addr[j*ADDR_W +: ADDR_W] != a_addr[ADDR_W-1:0]) lanes_same = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            folds <= '0;
    else if (start_take)   folds <= '0;
    else if (combine_fire) folds <= folds + 1'b1;
  end

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_all_groups_folded: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (folds == CW'(GROUPS)));

  a_r2_acc_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    start_take |=> (result == '0));

  a_r3_rows_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> lanes_same);

  a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !combine_fire) |=> $stable(a_addr));

  a_r7_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start_take) |=> $stable(result));

  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));

endmodule

bind banked_dot_unit dot_unit_chk #(
  .LANES(LANES), .GROUPS(GROUPS), .ADDR_W(ADDR_W), .ACC_W(ACC_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .done         (done),
  .result       (result),
  .a_addr       (a_addr),
  .b_addr       (b_addr),
  .busy         (busy),
  .combine_fire (combine_fire),
  .start_take   (start_take)
);

// File: tb/test_banked_dot_unit.sv
`timescale 1ns/1ps
module test_banked_dot_unit;

  localparam int LANES  = 4;
  localparam int VEC    = 16;
  localparam int DW     = 8;
  localparam int AW_ACC = 32;
  localparam int G      = VEC / LANES;
  localparam int AW     = (G > 1) ? $clog2(G) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [LANES*AW-1:0] a_addr, b_addr;
  logic [LANES*DW-1:0] a_rdata, b_rdata;
  logic done;
  logic [AW_ACC-1:0] result;

  logic [DW-1:0] va [VEC];
  logic [DW-1:0] vb [VEC];

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  // Synchronous banked memories: bank j, row r holds element LANES*r + j.
  always_ff @(posedge clk) begin
    for (int j = 0; j < LANES; j++) begin
      a_rdata[j*DW +: DW] <= va[LANES * int'(a_addr[j*AW +: AW]) + j];
      b_rdata[j*DW +: DW] <= vb[LANES * int'(b_addr[j*AW +: AW]) + j];
    end
  end

  banked_dot_unit #(.LANES(LANES), .VEC_LEN(VEC), .DATA_W(DW), .ACC_W(AW_ACC)) i_banked_dot_unit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .a_addr(a_addr), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_rdata(b_rdata),
    .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic longint expect_sum();
    longint s = 0;
    for (int e = 0; e < VEC; e++) s += longint'(va[e]) * longint'(vb[e]);
    return s % (longint'(1) << AW_ACC);
  endfunction

  function automatic bit rows_are(input int r);
    for (int j = 0; j < LANES; j++) begin
      if (int'(a_addr[j*AW +: AW]) != r || int'(b_addr[j*AW +: AW]) != r) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic run_dot(input bit poke_mid, input string tag);
    longint exp = expect_sum();
    bit rows_ok = 1'b1;
    bit quiet = 1'b1;
    int bad_cyc = -1;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < 3*G; c++) begin
      if (!rows_are(c / 3) && bad_cyc < 0) begin rows_ok = 1'b0; bad_cyc = c; end
      if (done) quiet = 1'b0;
      if (c == 1) chk(result == 0, {"R2 clear ", tag}, result, 0);
      if (poke_mid && c == 4) start = 1'b1;
      if (poke_mid && c == 5) start = 1'b0;
      @(negedge clk);
    end
    chk(rows_ok, {"R3 row sequence ", tag}, bad_cyc, -1);
    chk(quiet, {"R6 early done ", tag}, 1, 0);
    chk(done == 1'b1, {"R6 done timing ", tag}, done, 1);
    chk(longint'(result) == exp, {"R5 R4 sum ", tag}, result, exp);
    @(negedge clk);
    chk(done == 1'b0, {"R6 done width ", tag}, done, 0);
    chk(longint'(result) == exp, {"R7 hold ", tag}, result, exp);
    if (poke_mid) chk(longint'(result) == exp, {"R8 mid start ", tag}, result, exp);
    @(negedge clk);
  endtask

  initial begin
    #10000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int e = 0; e < VEC; e++) begin va[e] = '0; vb[e] = '0; end
    repeat (3) @(negedge clk);
    chk(done == 0, "R1 reset done", done, 0);
    chk(result == 0, "R1 reset result", result, 0);
    chk(a_addr == 0 && b_addr == 0, "R1 reset addr", a_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && result == 0, "R1 after reset", result, 0);

    run_dot(1'b0, "zeros");

    for (int e = 0; e < VEC; e++) begin va[e] = 8'hFF; vb[e] = 8'hFF; end
    run_dot(1'b0, "max");

    for (int e = 0; e < VEC; e++) begin va[e] = DW'(e); vb[e] = DW'(VEC - e); end
    run_dot(1'b0, "ramp");

    // One-hot sweeps pin each element to its bank and row (R3).
    for (int p = 0; p < VEC; p++) begin
      for (int e = 0; e < VEC; e++) begin va[e] = (e == p) ? 8'd1 : 8'd0; vb[e] = DW'(e + 1); end
      run_dot(1'b0, "R3 onehot a");
    end
    for (int p = 0; p < VEC; p++) begin
      for (int e = 0; e < VEC; e++) begin va[e] = DW'(2*e + 3); vb[e] = (e == p) ? 8'd7 : 8'd0; end
      run_dot(1'b0, "R3 onehot b");
    end

    for (int k = 0; k < 20; k++) begin
      for (int e = 0; e < VEC; e++) begin va[e] = DW'($urandom); vb[e] = DW'($urandom); end
      run_dot(1'b0, "random");
    end

    for (int e = 0; e < VEC; e++) begin va[e] = DW'(e * 13 + 1); vb[e] = DW'(200 - e); end
    run_dot(1'b1, "R8 busy start");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule